// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width modulated output from an 8-bit counter that advances only on a prescaled clock-enable tick. Software programs a period and a duty count through a simple write strobe interface. Each count has a staging copy that software writes and a working copy that the comparators use. While the channel runs, new values wait in the staging copies. They are promoted at a safe boundary, so a waveform is always wholly old or wholly new.

The counter either ramps up and wraps (edge-aligned) or ramps up to the period and back down to zero (center-aligned). A polarity input chooses whether the duty count measures the high time or the low time. Any write to the counter clears it and promotes the staging values at once. The count is always visible on an output port.

Top module: `pwm_channel`

## Requirements
- R1: After reset the counter reads 0, both staging and working counts are 0, the channel is off, and the output sits at its inactive level (the inverse of the polarity input).
- R2: The counter changes only on a cycle with tick high while the channel is on, or on a counter write. The enable input is sampled only on tick cycles, so raising or dropping it without a tick has no effect on the count or the output.
- R3: In edge-aligned mode (center input 0) with a nonzero period P, the counter steps 0,1,…,P-1. The tick at P-1 returns it to 0, and that tick ends the period.
- R4: In center-aligned mode (center input 1) with a nonzero period P, the counter climbs from 0 to P and then falls back to 0. The tick that brings it down to 0 ends the period, and the next tick climbs again.
- R5: While the channel is on, the channel is active when the period is 0, when the counter is below the duty count, or when the duty count is at least the period. The output equals the polarity input when active and its inverse otherwise.
- R6: A period or duty write while the channel is on changes only the staging copy. The working copies take the staging values at the end of a period, on a counter write, or on the tick that turns the channel off, and at no other time.
- R7: A period or duty write while the channel is off changes the staging and working copies in the same cycle.
- R8: A counter write, whatever its data, sets the counter to 0, restarts the center-aligned ramp in the upward direction, and promotes the staging counts.
- R9: On the tick that turns the channel off, the counter is cleared and stays 0 while off, and the output goes to its inactive level.
- R10: A duty count of 0 holds the output inactive for a whole period. A duty count at or above the period holds it active in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled count enable, one cycle per count step |
| en_i | input | 1 | Channel enable request, sampled on ticks |
| pol_i | input | 1 | Polarity: 1 gives an active-high output |
| center_i | input | 1 | 1 selects center-aligned counting, 0 edge-aligned |
| wr_per_i | input | 1 | Write strobe for the period count |
| wr_duty_i | input | 1 | Write strobe for the duty count |
| wr_cnt_i | input | 1 | Write strobe for the counter (data ignored) |
| wr_data_i | input | 8 | Write data shared by the strobes |
| cnt_o | output | 8 | Current counter value |
| pwm_o | output | 1 | Modulated output |

## Verification
The embedded properties assume that at most one write strobe is high in a cycle, since all three share one data bus. They also assume that reset is held for at least one clock edge before the first stimulus. The random stimulus raises a single strobe per cycle at most and changes the center input only together with a counter write, so a mode switch never lands mid-ramp. Period and duty data are drawn from small ranges, which makes wraps, turnarounds, zero periods and duty counts above the period occur often.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } ramp_dir_e;

   localparam int unsigned NUM_COUNTS = 2;
   localparam int unsigned IDX_PER    = 0;
   localparam int unsigned IDX_DUTY   = 1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         load_i,
   input  logic         wr_per_i,
   input  logic         wr_duty_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] per_o,
   output logic [W-1:0] duty_o
);
   logic [NUM_COUNTS-1:0] wr_sel;
   logic [W-1:0]          stage_q [NUM_COUNTS];
   logic [W-1:0]          work_q  [NUM_COUNTS];

   assign wr_sel[IDX_PER]  = wr_per_i;
   assign wr_sel[IDX_DUTY] = wr_duty_i;

   for (genvar g = 0; g < NUM_COUNTS; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q[g] <= '0;
            work_q[g]  <= '0;
         end else begin
            if (wr_sel[g]) begin
               stage_q[g] <= data_i;
            end
            if (wr_sel[g] && !run_i) begin
               work_q[g] <= data_i;
            end else if (load_i) begin
               work_q[g] <= stage_q[g];
            end
         end
      end

      assert_hold_work_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         (run_i && !load_i) |=> $stable(work_q[g]));

      assert_direct_write_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         (!run_i && wr_sel[g]) |=> (work_q[g] == $past(data_i)));
   end

   assign per_o  = work_q[IDX_PER];
   assign duty_o = work_q[IDX_DUTY];
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
   import pwm_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         run_i,
   input  logic         en_i,
   input  logic         center_i,
   input  logic         wr_cnt_i,
   input  logic [W-1:0] per_i,
   output logic [W-1:0] cnt_o,
   output logic         load_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q, cnt_d;
   ramp_dir_e    dir_q, dir_d;
   logic [W-1:0] step_cnt;
   ramp_dir_e    step_dir;
   logic         step_end;
   logic [W-1:0] edge_cnt;
   logic         edge_end;
   logic         stop_now;

   // edge-aligned step
   always_comb begin
      edge_end = 1'b0;
      if (cnt_q >= per_i - ONE) begin
         edge_cnt = '0;
         edge_end = 1'b1;
      end else begin
         edge_cnt = cnt_q + ONE;
      end
   end

   if (CENTER_EN) begin : g_center
      logic [W-1:0] ctr_cnt;
      ramp_dir_e    ctr_dir;
      logic         ctr_end;

      always_comb begin
         ctr_end = 1'b0;
         ctr_dir = dir_q;
         if (dir_q == DIR_UP && cnt_q < per_i) begin
            ctr_cnt = cnt_q + ONE;
         end else begin
            ctr_cnt = (cnt_q == '0) ? '0 : cnt_q - ONE;
            if (ctr_cnt == '0) begin
               ctr_end = 1'b1;
               ctr_dir = DIR_UP;
            end else begin
               ctr_dir = DIR_DOWN;
            end
         end
      end

      always_comb begin
         step_cnt = cnt_q;
         step_dir = dir_q;
         step_end = 1'b0;
         if (per_i != '0) begin
            if (center_i) begin
               step_cnt = ctr_cnt;
               step_dir = ctr_dir;
               step_end = ctr_end;
            end else begin
               step_cnt = edge_cnt;
               step_dir = DIR_UP;
               step_end = edge_end;
            end
         end
      end
   end else begin : g_edge_only
      logic unused_center;
      assign unused_center = center_i;
      always_comb begin
         step_cnt = cnt_q;
         step_dir = dir_q;
         step_end = 1'b0;
         if (per_i != '0) begin
            step_cnt = edge_cnt;
            step_dir = DIR_UP;
            step_end = edge_end;
         end
      end
   end

   assign stop_now = tick_i && run_i && !en_i;

   always_comb begin
      cnt_d  = cnt_q;
      dir_d  = dir_q;
      load_o = 1'b0;
      if (wr_cnt_i || stop_now) begin
         cnt_d  = '0;
         dir_d  = DIR_UP;
         load_o = 1'b1;
      end else if (tick_i && run_i) begin
         cnt_d  = step_cnt;
         dir_d  = step_dir;
         load_o = step_end;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= DIR_UP;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   assign cnt_o = cnt_q;

   assert_hold_no_tick_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_cnt_i) |=> $stable(cnt_q));

   assert_zero_when_off_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));

   assert_cnt_write_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt_i |=> (cnt_q == '0 && dir_q == DIR_UP));

   assert_load_timing_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> (tick_i || wr_cnt_i));
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] cnt_i,
   input  logic [W-1:0] per_i,
   input  logic [W-1:0] duty_i,
   input  logic         run_i,
   input  logic         pol_i,
   output logic         pwm_o
);
   logic active;

   assign active = (per_i == '0) || (cnt_i < duty_i) || (duty_i >= per_i);
   assign pwm_o  = run_i ? (active ~^ pol_i) : ~pol_i;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
   parameter int unsigned W         = 8,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         en_i,
   input  logic         pol_i,
   input  logic         center_i,
   input  logic         wr_per_i,
   input  logic         wr_duty_i,
   input  logic         wr_cnt_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] cnt_o,
   output logic         pwm_o
);
   if (W < 2) begin : g_bad_width
      $error("pwm_channel: W must be at least 2");
   end

   logic         run_q;
   logic         load;
   logic [W-1:0] per_w, duty_w;

   // enable is taken only on a tick
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (tick_i) begin
         run_q <= en_i;
      end
   end

   pwm_counter #(.W(W), .CENTER_EN(CENTER_EN)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .run_i    (run_q),
      .en_i     (en_i),
      .center_i (center_i),
      .wr_cnt_i (wr_cnt_i),
      .per_i    (per_w),
      .cnt_o    (cnt_o),
      .load_o   (load)
   );

   pwm_regs #(.W(W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q),
      .load_i    (load),
      .wr_per_i  (wr_per_i),
      .wr_duty_i (wr_duty_i),
      .data_i    (wr_data_i),
      .per_o     (per_w),
      .duty_o    (duty_w)
   );

   pwm_outstage #(.W(W)) i_out (
      .cnt_i  (cnt_o),
      .per_i  (per_w),
      .duty_i (duty_w),
      .run_i  (run_q),
      .pol_i  (pol_i),
      .pwm_o  (pwm_o)
   );

   assert_enable_on_tick_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(run_q));
endmodule

// File: tb/test_pwm_channel.sv
module test_pwm_channel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, en_i = 1'b0, pol_i = 1'b0, center_i = 1'b0;
   logic       wr_per_i = 1'b0, wr_duty_i = 1'b0, wr_cnt_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] cnt_o;
   logic       pwm_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;
   string cur_tag = "R5";

   always #5 clk = ~clk;

   pwm_channel i_pwm_channel (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i), .pol_i(pol_i),
      .center_i(center_i), .wr_per_i(wr_per_i), .wr_duty_i(wr_duty_i),
      .wr_cnt_i(wr_cnt_i), .wr_data_i(wr_data_i), .cnt_o(cnt_o), .pwm_o(pwm_o)
   );

   // reference model built from the requirements
   logic [7:0] m_cnt, m_pb, m_pa, m_db, m_da, nc;
   logic       m_up, m_en, nu, ld;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0; m_up <= 1'b1; m_en <= 1'b0;
         m_pb <= '0; m_pa <= '0; m_db <= '0; m_da <= '0;
      end else begin
         nc = m_cnt; nu = m_up; ld = 1'b0;
         if (wr_cnt_i || (tick_i && m_en && !en_i)) begin
            nc = '0; nu = 1'b1; ld = 1'b1;
         end else if (tick_i && m_en && m_pa != 8'd0) begin
            if (!center_i) begin
               nu = 1'b1;
               if (m_cnt >= m_pa - 8'd1) begin nc = '0; ld = 1'b1; end
               else nc = m_cnt + 8'd1;
            end else if (m_up && m_cnt < m_pa) begin
               nc = m_cnt + 8'd1;
            end else begin
               nc = (m_cnt == 8'd0) ? 8'd0 : m_cnt - 8'd1;
               if (nc == 8'd0) begin ld = 1'b1; nu = 1'b1; end
               else nu = 1'b0;
            end
         end
         m_cnt <= nc;
         m_up  <= nu;
         if (wr_per_i) m_pb <= wr_data_i;
         if (wr_duty_i) m_db <= wr_data_i;
         if (wr_per_i && !m_en) m_pa <= wr_data_i;
         else if (ld) m_pa <= m_pb;
         if (wr_duty_i && !m_en) m_da <= wr_data_i;
         else if (ld) m_da <= m_db;
         if (tick_i) m_en <= en_i;
      end
   end

   function automatic logic exp_pwm();
      logic act;
      act = (m_pa == 8'd0) || (m_cnt < m_da) || (m_da >= m_pa);
      return m_en ? (act ~^ pol_i) : ~pol_i;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check(tag, "counter", int'(cnt_o), int'(m_cnt));
      check(tag, "output", int'(pwm_o), int'(exp_pwm()));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      compare(cur_tag);
   endtask

   task automatic write(input int kind, input logic [7:0] d);
      wr_data_i = d;
      wr_per_i  = (kind == 0);
      wr_duty_i = (kind == 1);
      wr_cnt_i  = (kind == 2);
      step();
      wr_per_i = 1'b0; wr_duty_i = 1'b0; wr_cnt_i = 1'b0;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
         summary();
      end
   end

   initial begin
      int mx, highs, prev;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "reset counter", int'(cnt_o), 0);
      check("R1", "reset output", int'(pwm_o), 1);

      // R7 writes while off go straight through; R3 edge ramp
      tick_i = 1'b1; pol_i = 1'b1; center_i = 1'b0;
      cur_tag = "R7";
      write(0, 8'd4);
      write(1, 8'd1);
      en_i = 1'b1;
      step();
      cur_tag = "R3";
      mx = 0; highs = 0;
      for (int i = 0; i < 8; i++) begin
         if (cnt_o > mx) mx = cnt_o;
         if (pwm_o) highs++;
         step();
      end
      check("R3", "edge max count", mx, 3);
      check("R5", "active cycles with duty 1 of 4", highs, 2);

      // R6 staged period write mid-run
      cur_tag = "R6";
      while (cnt_o != 8'd1) step();
      write(0, 8'd6);
      prev = cnt_o;
      while (cnt_o != 8'd0) begin prev = cnt_o; step(); end
      check("R6", "old period finishes", prev, 3);
      mx = 0;
      for (int i = 0; i < 6; i++) begin
         if (cnt_o > mx) mx = cnt_o;
         step();
      end
      check("R6", "new period after boundary", mx, 5);

      // R2 no tick: count and enable frozen
      cur_tag = "R2";
      tick_i = 1'b0;
      prev = cnt_o;
      step(); step();
      en_i = 1'b0;
      step(); step(); step();
      check("R2", "count frozen without tick", int'(cnt_o), prev);
      check("R2", "enable ignored without tick", int'(pwm_o), int'(exp_pwm()));
      check("R2", "still running", int'(m_en), 1);

      // R9 disable on tick
      cur_tag = "R9";
      tick_i = 1'b1;
      step();
      check("R9", "counter cleared", int'(cnt_o), 0);
      check("R9", "output inactive", int'(pwm_o), 0);

      // R4 center ramp, R7 direct while off
      cur_tag = "R4";
      center_i = 1'b1;
      write(0, 8'd3);
      write(1, 8'd1);
      en_i = 1'b1;
      step();
      mx = 0; highs = 0;
      for (int i = 0; i < 12; i++) begin
         if (cnt_o > mx) mx = cnt_o;
         if (pwm_o) highs++;
         if (i == 4) check("R4", "falling half", int'(cnt_o), 2);
         step();
      end
      check("R7", "direct period in effect", mx, 3);
      check("R4", "active cycles centered", highs, 2);

      // R8 counter write
      cur_tag = "R8";
      while (cnt_o != 8'd2 || m_up) step();
      write(2, 8'hA5);
      check("R8", "counter write clears", int'(cnt_o), 0);
      step();
      check("R8", "ramp restarts upward", int'(cnt_o), 1);

      // R10 duty 0 -> inactive, duty >= period -> active
      cur_tag = "R10";
      en_i = 1'b0; step();
      center_i = 1'b0;
      write(1, 8'd0);
      en_i = 1'b1; step();
      highs = 0;
      for (int i = 0; i < 8; i++) begin if (pwm_o) highs++; step(); end
      check("R10", "duty 0 never active", highs, 0);
      en_i = 1'b0; step();
      center_i = 1'b1;
      write(1, 8'd9);
      en_i = 1'b1; step();
      highs = 0;
      for (int i = 0; i < 8; i++) begin if (pwm_o) highs++; step(); end
      check("R10", "duty above period always active", highs, 8);

      // random phase
      cur_tag = "R5";
      for (int i = 0; i < 4000; i++) begin
         int r;
         tick_i = ($urandom % 3) != 0;
         r = $urandom % 40;
         wr_per_i = 1'b0; wr_duty_i = 1'b0; wr_cnt_i = 1'b0;
         case (r)
            0: begin wr_per_i = 1'b1;  wr_data_i = 8'($urandom % 10); end
            1: begin wr_duty_i = 1'b1; wr_data_i = 8'($urandom % 12); end
            2: begin wr_cnt_i = 1'b1;  wr_data_i = 8'($urandom); center_i = $urandom % 2; end
            3: en_i = ~en_i;
            4: pol_i = ~pol_i;
            default: ;
         endcase
         step();
      end
      wr_per_i = 1'b0; wr_duty_i = 1'b0; wr_cnt_i = 1'b0;
      step();
      summary();
   end
endmodule